// File: doc/BRIEF.md
# Partial-Write Merge Buffer

This block sits between a requester that writes whole cache lines and a DRAM controller whose bursts are always four beats of 64 bits, so one line is 32 bytes. The requester hands over a line-aligned address, a 256-bit data word and a 32-bit byte-enable mask in a single valid/ready transfer. The DRAM side never receives a masked write. Every line that reaches memory is complete.

When all 32 enables are set, the block writes the line out at once. When only some are set, it first requests a line read and collects the four returned beats into its line buffer. It then overlays the enabled bytes of the new data on that buffer and writes the complete merged line back. An all-zero mask produces no memory traffic. Each finished request is acknowledged with a one-cycle done pulse.

Top module: `line_merge_wbuf`

## Requirements
- R1: After reset, `req_ready` is 1 and `req_done`, `rd_req_valid`, `rd_beat` handling and `wr_valid` are idle, so `rd_req_valid`, `wr_valid` and `req_done` are 0.
- R2: A request whose mask is all ones (32'hFFFFFFFF) issues no read request and writes the request data as the line.
- R3: A request with a mask that is neither all ones nor zero issues exactly one read request at the request address, and this happens before any write beat.
- R4: Read beat k (k = 0..3, in arrival order) fills line bytes 8k to 8k+7, which are bits 64k+63 down to 64k.
- R5: In the merged line, a byte whose enable bit is 1 takes the request byte, and a byte whose enable bit is 0 keeps the byte read from memory.
- R6: Every line is written as exactly four beats at the request address, beat 0 (bytes 0..7) first. `wr_last` is 1 on the fourth beat only.
- R7: A request with an all-zero mask produces no read request and no write beat. `req_done` pulses in the cycle after acceptance.
- R8: `req_ready` stays 0 from acceptance until the done pulse. `req_done` is high for one cycle only, and `req_ready` is 1 again in the following cycle.
- R9: While `rd_req_ready` is 0, `rd_req_valid` and its address hold steady. While `wr_ready` is 0, `wr_valid`, `wr_data`, `wr_addr` and `wr_last` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | AW | Line-aligned request address |
| req_data | input | 256 | New line data, byte 0 in bits 7:0 |
| req_be | input | 32 | Byte enables, bit b covers byte b |
| req_done | output | 1 | One-cycle completion pulse |
| rd_req_valid | output | 1 | Line read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Address of the line to read |
| rd_beat_valid | input | 1 | Read data beat present |
| rd_beat_data | input | 64 | Read data beat |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | AW | Line address of the write |
| wr_data | output | 64 | Write data beat |
| wr_last | output | 1 | Final beat of the line |

## Verification
The bench keeps a memory model that the block reads from and writes to, and compares every stored line with a merge computed in the bench. The corner cases it targets are these. A single enabled byte at either end of the line catches a merge that is off by one byte. A mask that covers exactly one beat catches beats placed in the wrong slot, since the line would then come back with rotated data. It also tests the all-ones mask, where a stray read would show up in the read count, and the zero mask, where any write would change memory. Random backpressure on both memory handshakes and gaps between read beats expose a design that drops or repeats a beat under stalls, or that lets its data change while waiting.

// File: rtl/line_merge_wbuf.sv
module line_merge_wbuf #(
  parameter int AW     = 32,
  parameter int BEAT_W = 64,
  parameter int BEATS  = 4,
  localparam int LINE_W = BEAT_W * BEATS,
  localparam int LINE_B = LINE_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic [LINE_W-1:0] req_data,
  input  logic [LINE_B-1:0] req_be,
  output logic              req_done,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [AW-1:0]     rd_req_addr,
  input  logic              rd_beat_valid,
  input  logic [BEAT_W-1:0] rd_beat_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [BEAT_W-1:0] wr_data,
  output logic              wr_last
);
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  typedef enum logic [2:0] {IDLE, READ_REQ, COLLECT, MERGE, WRITE, DONE} st_t;

  st_t               st;
  logic [AW-1:0]     addr_q;
  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] data_q;
  logic [LINE_B-1:0] be_q;
  logic [CW-1:0]     cnt;

  wire accept = req_valid && req_ready;

  assign req_ready    = (st == IDLE);
  assign req_done     = (st == DONE);
  assign rd_req_valid = (st == READ_REQ);
  assign rd_req_addr  = addr_q;
  assign wr_valid     = (st == WRITE);
  assign wr_addr      = addr_q;
  assign wr_data      = line_q[cnt*BEAT_W +: BEAT_W];
  assign wr_last      = (st == WRITE) && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      addr_q <= '0;
      line_q <= '0;
      data_q <= '0;
      be_q   <= '0;
      cnt    <= '0;
    end else begin
      case (st)
        IDLE: if (accept) begin
          addr_q <= req_addr;
          data_q <= req_data;
          be_q   <= req_be;
          cnt    <= '0;
          if (~|req_be) st <= DONE;
          else if (&req_be) begin
            line_q <= req_data;
            st     <= WRITE;
          end else st <= READ_REQ;
        end
        READ_REQ: if (rd_req_ready) begin
          cnt <= '0;
          st  <= COLLECT;
        end
        COLLECT: if (rd_beat_valid) begin
          line_q[cnt*BEAT_W +: BEAT_W] <= rd_beat_data;
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= MERGE;
        end
        MERGE: begin
          for (int b = 0; b < LINE_B; b++)
            if (be_q[b]) line_q[b*8 +: 8] <= data_q[b*8 +: 8];
          cnt <= '0;
          st  <= WRITE;
        end
        WRITE: if (wr_ready) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= DONE;
        end
        DONE: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/line_merge_wbuf_chk.sv
module line_merge_wbuf_chk #(
  parameter int AW     = 32,
  parameter int BEAT_W = 64,
  parameter int BEATS  = 4,
  localparam int LINE_W = BEAT_W * BEATS,
  localparam int LINE_B = LINE_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [AW-1:0]     req_addr,
  input logic [LINE_W-1:0] req_data,
  input logic [LINE_B-1:0] req_be,
  input logic              req_done,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [AW-1:0]     rd_req_addr,
  input logic              rd_beat_valid,
  input logic [BEAT_W-1:0] rd_beat_data,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [AW-1:0]     wr_addr,
  input logic [BEAT_W-1:0] wr_data,
  input logic              wr_last
);
  int wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) wcnt <= 0;
    else if (wr_valid && wr_ready) wcnt <= (wcnt == BEATS - 1) ? 0 : wcnt + 1;
  end

  assert_full_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (&req_be)) |=> (wr_valid && !rd_req_valid));

  assert_rd_wr_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && wr_valid));

  assert_last_on_fourth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_last == (wcnt == BEATS - 1)));

  assert_zero_mask_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(|req_be)) |=> req_done);

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> (!req_done && req_ready));

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr) && $stable(wr_last)));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
endmodule

bind line_merge_wbuf line_merge_wbuf_chk #(.AW(AW), .BEAT_W(BEAT_W), .BEATS(BEATS)) u_chk (.*);

// File: tb/sim_line_merge_wbuf.sv
module sim_line_merge_wbuf;
  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic         req_valid = 0, req_ready, req_done;
  logic [31:0]  req_addr = 0;
  logic [255:0] req_data = 0;
  logic [31:0]  req_be = 0;
  logic         rd_req_valid, rd_req_ready = 0, rd_beat_valid = 0;
  logic [31:0]  rd_req_addr;
  logic [63:0]  rd_beat_data = 0;
  logic         wr_valid, wr_ready = 0, wr_last;
  logic [31:0]  wr_addr;
  logic [63:0]  wr_data;

  line_merge_wbuf u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic [255:0] mem [16];
  int n_rd, n_wr, wbk, pend, bk;
  logic [3:0] rd_idx;
  logic [31:0] cur_addr;
  bit cur_partial;
  bit pw_stall, pr_stall;
  logic [63:0] pw_data;
  logic [31:0] pw_addr, pr_addr;
  bit pw_last;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] merge(input logic [255:0] old, input logic [255:0] nw, input logic [31:0] be);
    logic [255:0] r = old;
    for (int b = 0; b < 32; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      rd_req_ready = 0; rd_beat_valid = 0; wr_ready = 0; pend = 0;
      pw_stall = 0; pr_stall = 0;
    end else begin
      if (pw_stall)
        chk(wr_valid && wr_data == pw_data && wr_addr == pw_addr && wr_last == pw_last,
            "R9 write hold", {192'b0, wr_data}, {192'b0, pw_data});
      if (pr_stall)
        chk(rd_req_valid && rd_req_addr == pr_addr, "R9 read hold",
            {224'b0, rd_req_addr}, {224'b0, pr_addr});
      if (pend > 0 && ($urandom % 4) != 0) begin
        rd_beat_valid = 1;
        rd_beat_data = mem[rd_idx][bk*64 +: 64];
        bk++; pend--;
      end else rd_beat_valid = 0;
      rd_req_ready = ($urandom % 3) != 0;
      if (rd_req_valid && rd_req_ready) begin
        n_rd++;
        chk(rd_req_addr == cur_addr, "R3 read address", {224'b0, rd_req_addr}, {224'b0, cur_addr});
        rd_idx = rd_req_addr[8:5]; pend = 4; bk = 0;
      end
      wr_ready = ($urandom % 3) != 0;
      if (wr_valid && wr_ready) begin
        if (cur_partial && n_rd == 0) chk(0, "R3 write before read", 256'd0, 256'd1);
        chk(wr_addr == cur_addr && wr_last == (wbk == 3), "R6 beat addr/last",
            {223'b0, wr_last, wr_addr}, {223'b0, (wbk == 3), cur_addr});
        mem[wr_addr[8:5]][wbk*64 +: 64] = wr_data;
        wbk = (wbk + 1) % 4; n_wr++;
      end
      pw_stall = wr_valid && !wr_ready;
      pw_data = wr_data; pw_addr = wr_addr; pw_last = wr_last;
      pr_stall = rd_req_valid && !rd_req_ready;
      pr_addr = rd_req_addr;
    end
  end

  task automatic do_req(input logic [3:0] idx, input logic [255:0] data, input logic [31:0] be);
    logic [255:0] exp;
    int t;
    bit busy_ok;
    bit full = (be == 32'hFFFF_FFFF);
    bit zero = (be == 0);
    exp = zero ? mem[idx] : merge(mem[idx], data, be);
    @(negedge clk);
    n_rd = 0; n_wr = 0; wbk = 0;
    cur_addr = {23'b0, idx, 5'b0};
    cur_partial = !full && !zero;
    req_valid = 1; req_addr = cur_addr; req_data = data; req_be = be;
    t = 0;
    while (!req_ready && t < 1000) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 0; req_data = ~data; req_be = ~be; req_addr = ~cur_addr;
    busy_ok = 1; t = 0;
    while (!req_done && t < 2000) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk); t++;
    end
    chk(t < 2000, "watchdog", 256'(t), 256'd0);
    chk(busy_ok && !req_ready, "R8 ready low while busy", {255'b0, req_ready}, 256'd0);
    if (zero) chk(t == 0, "R7 done next cycle", 256'(t), 256'd0);
    @(negedge clk);
    chk(!req_done && req_ready, "R8 single pulse then ready", {254'b0, req_done, req_ready}, 256'd1);
    chk(mem[idx] == exp, zero ? "R7 memory untouched" : (full ? "R2 full line" : "R4 R5 merged line"),
        mem[idx], exp);
    chk(n_rd == (cur_partial ? 1 : 0), "R3 R2 R7 read count", 256'(n_rd), 256'(cur_partial ? 1 : 0));
    chk(n_wr == (zero ? 0 : 4), "R6 R7 write beats", 256'(n_wr), 256'(zero ? 0 : 4));
  endtask

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 16; i++) mem[i] = rnd256();
    repeat (3) @(negedge clk);
    chk(req_ready && !req_done && !rd_req_valid && !wr_valid, "R1 reset state",
        {252'b0, req_ready, req_done, rd_req_valid, wr_valid}, 256'h8);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !req_done && !rd_req_valid && !wr_valid, "R1 idle after reset",
        {252'b0, req_ready, req_done, rd_req_valid, wr_valid}, 256'h8);
    do_req(4'd1, rnd256(), 32'hFFFF_FFFF);
    do_req(4'd2, rnd256(), 32'h0000_0000);
    do_req(4'd3, rnd256(), 32'h0000_0001);
    do_req(4'd4, rnd256(), 32'h8000_0000);
    do_req(4'd5, rnd256(), 32'h00FF_0000);
    do_req(4'd6, rnd256(), 32'h5555_5555);
    do_req(4'd7, rnd256(), 32'h7FFF_FFFF);
    do_req(4'd7, rnd256(), 32'hFF00_0000);
    for (int n = 0; n < 60; n++) begin
      int sel = $urandom % 8;
      logic [31:0] be = (sel == 0) ? 32'hFFFF_FFFF : (sel == 1) ? 32'h0 : $urandom;
      do_req(4'($urandom % 16), rnd256(), be);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule